// File: doc/BRIEF.md
# SMI Trigger and Trap Capture Controller

This block decides when the processor enters system management mode and keeps the trap context that the handler reads. An active-low, asynchronous SMI input is brought into the clock domain and watched for falling edges. Each accepted edge produces a one-cycle request to the core. A resume strobe ends the handler. If another falling edge arrived while the handler ran, the resume strobe starts a new request at once.

In the cycle a request is taken, the block copies the bus cycle in flight into a header image. The image holds the cycle kind (memory or I/O), address, data, a data-size code and the current and next instruction pointers. One data slot serves both memory and I/O traps, and a flag tells them apart. A status bit shows whether the data word is meaningful.

The block also holds two configuration registers: the SMM base/limit word and the header address. Software can reach them only while a map-enable bit is set. Any write to the base/limit register overwrites the header address with a value derived from the new base, so software must program the base first.

Top module: `smi_trap_ctrl`

## Requirements
- R1: A falling edge of the synchronized SMI input while not in SMM raises `smi_req` for exactly one cycle and sets `smm_active`. `smi_req` is never high in two consecutive cycles.
- R2: A low level held on the SMI input never raises another request. A falling edge that arrives while `smm_active` is high raises no request at that time.
- R3: A `rsm_pulse` while in SMM raises a new one-cycle request, and keeps `smm_active` high, when a falling edge was seen during the handler. Otherwise it clears `smm_active` and raises no request.
- R4: On an I/O trap (`bus_is_mem`=0), the address is captured for both IN and OUT cycles. `cap_dvalid` is 1 only for an OUT cycle (`bus_is_wr`=1) with `bus_cycle`=1, and `cap_mem` is 0.
- R5: On a memory trap (`bus_is_mem`=1), `cap_mem` is 1, the address is captured for reads and writes, and `cap_dvalid` is 1 only for writes. The data word goes into the same `cap_data` slot that I/O data uses.
- R6: `cap_size` encodes the byte count on `bus_bytes`: 1→2'b00, 2→2'b01, 4→2'b10, and any other value→2'b11.
- R7: The capture outputs change only in the cycle a request is taken. A resume without a new request leaves them unchanged.
- R8: When the trapped cycle belongs to a repeated string I/O instruction (`bus_rep_str`=1), `cap_ip_next` equals `cap_ip_cur`.
- R9: The effective header address (`hdr_eff_addr`, and the readback with `cfg_sel`=1) always has bits [1:0] equal to zero. The other bits follow the written value.
- R10: A write to the base/limit register (`cfg_sel`=0) overwrites the header address with {wdata[31:12],12'h000} + (32'h1000 << wdata[2:0]), truncated to 32 bits. After reset both registers hold 0 and `hdr_eff_addr` is 32'h0000_1000.
- R11: With `map_en`=0, configuration writes are ignored and `cfg_rdata` reads 0. With `map_en`=1, `cfg_rd` returns the selected register on `cfg_rdata` in the same cycle.
- R12: While `rst` is high, `smi_req` and `smm_active` are 0 and all capture outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_n_async | input | 1 | Asynchronous active-low SMI input |
| rsm_pulse | input | 1 | One-cycle strobe when the resume instruction executes |
| smi_req | output | 1 | One-cycle SMM entry request |
| smm_active | output | 1 | High from a taken request until resume |
| bus_cycle | input | 1 | A bus cycle is in flight |
| bus_is_mem | input | 1 | In-flight cycle is a memory cycle (0: I/O) |
| bus_is_wr | input | 1 | In-flight cycle is a write / OUT |
| bus_rep_str | input | 1 | In-flight cycle comes from a repeated string I/O instruction |
| bus_bytes | input | 3 | Byte count of the in-flight cycle |
| bus_addr | input | 32 | Address of the in-flight cycle |
| bus_data | input | 32 | Write data of the in-flight cycle |
| ip_cur | input | 32 | Pointer to the executing instruction |
| ip_next | input | 32 | Pointer to the following instruction |
| cap_mem | output | 1 | Captured kind: 1 memory, 0 I/O |
| cap_dvalid | output | 1 | Captured data word is meaningful |
| cap_size | output | 2 | Captured size code |
| cap_addr | output | 32 | Captured address |
| cap_data | output | 32 | Captured shared data slot |
| cap_ip_cur | output | 32 | Captured current pointer |
| cap_ip_next | output | 32 | Captured next pointer |
| map_en | input | 1 | Enables configuration register access |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 1 | 0: base/limit register, 1: header address register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| hdr_eff_addr | output | 32 | Effective header address |

## Verification
The bench builds the block with the default two-stage synchronizer. This keeps the path from a pin edge to `smi_req` at three clock edges, so a short hold of the SMI input is enough to exercise a falling edge during the handler followed by a resume on the next cycle. The base/limit values are chosen so that the size code shifts the span several steps and the recomputed header address lands well away from its reset value. This makes a missed overwrite visible.

// File: rtl/smi_pkg.sv
package smi_pkg;

    localparam int XLEN       = 32;
    localparam int PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } size_code_t;

    // Bus cycle seen by the trap capture
    typedef struct packed {
        logic            in_cycle;
        logic            is_mem;
        logic            is_wr;
        logic            rep_str;
        logic [2:0]      bytes;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] data;
        logic [XLEN-1:0] cur_ip;
        logic [XLEN-1:0] nxt_ip;
    } trap_bus_t;

    // Header image kept for the handler
    typedef struct packed {
        logic            mem;
        logic            dvalid;
        size_code_t      size;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] data;
        logic [XLEN-1:0] cur_ip;
        logic [XLEN-1:0] nxt_ip;
    } trap_rec_t;

    function automatic size_code_t size_enc(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_WORD;
            3'd4:    return SZ_DWORD;
            default: return SZ_RSVD;
        endcase
    endfunction

    // Header sits at the top of the SMM region: page-aligned base plus span
    function automatic logic [XLEN-1:0] hdr_top(input logic [XLEN-1:0] base_lim);
        logic [XLEN-1:0] base_al;
        logic [XLEN-1:0] span;
        base_al = {base_lim[XLEN-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        span    = XLEN'(1) << (PAGE_SHIFT + int'(base_lim[2:0]));
        return base_al + span;
    endfunction

endpackage

// File: rtl/smi_edge_unit.sv
module smi_edge_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smi_n_async,
    input  logic rsm_pulse,
    output logic take,
    output logic smi_req,
    output logic in_smm
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          s_prev;
    logic          s_now;
    logic          fall;
    logic          pend_q;
    logic          rsm_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            s_prev <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], smi_n_async};
            s_prev <= s_now;
        end
    end

    assign s_now   = sync_q[LAST];
    assign fall    = s_prev & ~s_now;
    assign rsm_hit = rsm_pulse & in_smm;
    assign take    = (fall & ~in_smm) | (rsm_hit & (pend_q | fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_smm  <= 1'b0;
            pend_q  <= 1'b0;
            smi_req <= 1'b0;
        end else begin
            smi_req <= take;
            if (take)         in_smm <= 1'b1;
            else if (rsm_hit) in_smm <= 1'b0;
            if (take)                pend_q <= 1'b0;
            else if (fall && in_smm) pend_q <= 1'b1;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> !smi_req); // R1
    AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!s_now && !s_prev && !rsm_pulse) |=> !smi_req); // R2
    AST_RSM_REARM: assert property (@(posedge clk) disable iff (rst)
        (rsm_pulse && in_smm && pend_q) |=> (smi_req && in_smm)); // R3
    AST_RSM_EXIT: assert property (@(posedge clk) disable iff (rst)
        (rsm_pulse && in_smm && !pend_q && !(s_prev && !s_now)) |=> (!in_smm && !smi_req)); // R3

endmodule

// File: rtl/smi_trap_capture.sv
module smi_trap_capture
    import smi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  trap_bus_t bus,
    output trap_rec_t rec
);
    trap_rec_t nxt;

    always_comb begin
        nxt.mem    = bus.is_mem;
        nxt.dvalid = bus.in_cycle & bus.is_wr;
        nxt.size   = size_enc(bus.bytes);
        nxt.addr   = bus.addr;
        nxt.data   = bus.data;
        nxt.cur_ip = bus.cur_ip;
        nxt.nxt_ip = bus.rep_str ? bus.cur_ip : bus.nxt_ip;
    end

    always_ff @(posedge clk) begin
        if (rst)       rec <= '0;
        else if (take) rec <= nxt;
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(rec)); // R7
    AST_REP_IP: assert property (@(posedge clk) disable iff (rst)
        (take && bus.rep_str) |=> (rec.cur_ip == rec.nxt_ip)); // R8
    AST_DVALID_RD: assert property (@(posedge clk) disable iff (rst)
        (take && !bus.is_wr) |=> !rec.dvalid); // R4

endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            map_en,
    input  logic            cfg_wr,
    input  logic            cfg_rd,
    input  logic            cfg_sel,
    input  logic [XLEN-1:0] cfg_wdata,
    output logic [XLEN-1:0] cfg_rdata,
    output logic [XLEN-1:0] hdr_eff_addr
);
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] hdr_q;
    logic            wr_ok;

    assign wr_ok        = map_en & cfg_wr;
    assign hdr_eff_addr = {hdr_q[XLEN-1:2], 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            hdr_q  <= hdr_top('0);
        end else if (wr_ok) begin
            if (!cfg_sel) begin
                base_q <= cfg_wdata;
                hdr_q  <= hdr_top(cfg_wdata);
            end else begin
                hdr_q  <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (map_en && cfg_rd)
            cfg_rdata = cfg_sel ? hdr_eff_addr : base_q;
    end

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !map_en |=> ($stable(base_q) && $stable(hdr_q))); // R11
    AST_BASE_RECOMP: assert property (@(posedge clk) disable iff (rst)
        (map_en && cfg_wr && !cfg_sel) |=> (hdr_eff_addr == hdr_top($past(cfg_wdata)))); // R10

endmodule

// File: rtl/smi_trap_ctrl.sv
module smi_trap_ctrl
    import smi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smi_n_async,
    input  logic        rsm_pulse,
    output logic        smi_req,
    output logic        smm_active,
    input  logic        bus_cycle,
    input  logic        bus_is_mem,
    input  logic        bus_is_wr,
    input  logic        bus_rep_str,
    input  logic [2:0]  bus_bytes,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_data,
    input  logic [31:0] ip_cur,
    input  logic [31:0] ip_next,
    output logic        cap_mem,
    output logic        cap_dvalid,
    output logic [1:0]  cap_size,
    output logic [31:0] cap_addr,
    output logic [31:0] cap_data,
    output logic [31:0] cap_ip_cur,
    output logic [31:0] cap_ip_next,
    input  logic        map_en,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] hdr_eff_addr
);
    logic      take;
    trap_bus_t bus;
    trap_rec_t rec;

    smi_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst         (rst),
        .smi_n_async (smi_n_async),
        .rsm_pulse   (rsm_pulse),
        .take        (take),
        .smi_req     (smi_req),
        .in_smm      (smm_active)
    );

    always_comb begin
        bus.in_cycle = bus_cycle;
        bus.is_mem   = bus_is_mem;
        bus.is_wr    = bus_is_wr;
        bus.rep_str  = bus_rep_str;
        bus.bytes    = bus_bytes;
        bus.addr     = bus_addr;
        bus.data     = bus_data;
        bus.cur_ip   = ip_cur;
        bus.nxt_ip   = ip_next;
    end

    smi_trap_capture u_cap (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .bus  (bus),
        .rec  (rec)
    );

    assign cap_mem     = rec.mem;
    assign cap_dvalid  = rec.dvalid;
    assign cap_size    = rec.size;
    assign cap_addr    = rec.addr;
    assign cap_data    = rec.data;
    assign cap_ip_cur  = rec.cur_ip;
    assign cap_ip_next = rec.nxt_ip;

    smi_cfg_regs u_cfg (
        .clk          (clk),
        .rst          (rst),
        .map_en       (map_en),
        .cfg_wr       (cfg_wr),
        .cfg_rd       (cfg_rd),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .hdr_eff_addr (hdr_eff_addr)
    );

    AST_ENTRY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> smm_active); // R1

endmodule

// File: tb/smi_trap_ctrl_tb.sv
module smi_trap_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        smi_n_async, rsm_pulse;
    logic        smi_req, smm_active;
    logic        bus_cycle, bus_is_mem, bus_is_wr, bus_rep_str;
    logic [2:0]  bus_bytes;
    logic [31:0] bus_addr, bus_data, ip_cur, ip_next;
    logic        cap_mem, cap_dvalid;
    logic [1:0]  cap_size;
    logic [31:0] cap_addr, cap_data, cap_ip_cur, cap_ip_next;
    logic        map_en, cfg_wr, cfg_rd, cfg_sel;
    logic [31:0] cfg_wdata, cfg_rdata, hdr_eff_addr;

    int tests = 0;
    int fails = 0;
    int req_cnt = 0;
    bit req_double = 0;
    bit req_prev = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_trap_ctrl dut_i (.*);

    always @(negedge clk) begin
        if (!rst && smi_req) begin
            req_cnt++;
            if (req_prev) req_double = 1;
        end
        req_prev = !rst && smi_req;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic smi_low();  smi_n_async = 1'b0; cycles(6); endtask
    task automatic smi_high(); smi_n_async = 1'b1; cycles(5); endtask

    task automatic do_rsm();
        @(negedge clk); rsm_pulse = 1'b1;
        @(negedge clk); rsm_pulse = 1'b0;
        cycles(3);
    endtask

    task automatic set_bus(input logic mem, input logic wr, input logic rep,
                           input logic [2:0] nb, input logic [31:0] a, input logic [31:0] d,
                           input logic [31:0] ic, input logic [31:0] inx);
        bus_cycle = 1'b1; bus_is_mem = mem; bus_is_wr = wr; bus_rep_str = rep;
        bus_bytes = nb; bus_addr = a; bus_data = d; ip_cur = ic; ip_next = inx;
    endtask

    task automatic cfg_write(input logic en, input logic sel, input logic [31:0] d);
        @(negedge clk); map_en = en; cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic en, input logic sel, output logic [31:0] d);
        @(negedge clk); map_en = en; cfg_sel = sel; cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        @(negedge clk); cfg_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; smi_n_async = 1'b1; rsm_pulse = 1'b0;
        set_bus(1'b0, 1'b0, 1'b0, 3'd1, 32'h0, 32'h0, 32'h0, 32'h0);
        bus_cycle = 1'b0;
        map_en = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        cycles(4);
        chk("R12", "smi_req in reset", {31'b0, smi_req}, 32'd0);
        chk("R12", "smm_active in reset", {31'b0, smm_active}, 32'd0);
        chk("R12", "cap_addr in reset", cap_addr, 32'd0);
        rst = 1'b0;
        cycles(2);
        chk("R10", "header reset value", hdr_eff_addr, 32'h0000_1000);
    endtask

    task automatic t_io_out();
        int c0;
        set_bus(1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_03F8, 32'h0000_00A5, 32'h100, 32'h102);
        c0 = req_cnt;
        smi_low();
        chk("R1", "one request on fall", req_cnt, c0 + 1);
        chk("R1", "smm_active after entry", {31'b0, smm_active}, 32'd1);
        chk("R4", "io out addr", cap_addr, 32'h0000_03F8);
        chk("R4", "io out data", cap_data, 32'h0000_00A5);
        chk("R4", "io out dvalid", {31'b0, cap_dvalid}, 32'd1);
        chk("R4", "io M flag", {31'b0, cap_mem}, 32'd0);
        chk("R6", "size 1 byte", {30'b0, cap_size}, 32'd0);
        chk("R8", "non-rep next ip", cap_ip_next, 32'h102);
        cycles(10);
        chk("R2", "held low no retrigger", req_cnt, c0 + 1);
        do_rsm();
        chk("R3", "rsm without edge no request", req_cnt, c0 + 1);
        chk("R3", "rsm exits smm", {31'b0, smm_active}, 32'd0);
        chk("R7", "capture kept across rsm", cap_addr, 32'h0000_03F8);
        smi_high();
        chk("R2", "rise no request", req_cnt, c0 + 1);
    endtask

    task automatic t_io_in_pending();
        int c0;
        set_bus(1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_0060, 32'hDEAD_BEEF, 32'h200, 32'h201);
        c0 = req_cnt;
        smi_low();
        chk("R4", "io in addr", cap_addr, 32'h0000_0060);
        chk("R4", "io in dvalid clear", {31'b0, cap_dvalid}, 32'd0);
        chk("R6", "size 2 bytes", {30'b0, cap_size}, 32'd1);
        smi_high();
        smi_low();
        chk("R2", "edge in handler no request", req_cnt, c0 + 1);
        set_bus(1'b1, 1'b1, 1'b0, 3'd4, 32'h0008_1000, 32'h1234_5678, 32'h300, 32'h304);
        cycles(1);
        chk("R7", "capture holds while in smm", cap_addr, 32'h0000_0060);
        do_rsm();
        chk("R3", "rsm re-raises pending", req_cnt, c0 + 2);
        chk("R3", "still in smm after re-raise", {31'b0, smm_active}, 32'd1);
        chk("R5", "mem M flag", {31'b0, cap_mem}, 32'd1);
        chk("R5", "mem write dvalid", {31'b0, cap_dvalid}, 32'd1);
        chk("R5", "mem data shares slot", cap_data, 32'h1234_5678);
        chk("R6", "size 4 bytes", {30'b0, cap_size}, 32'd2);
        do_rsm();
        chk("R3", "second rsm exits", {31'b0, smm_active}, 32'd0);
        chk("R3", "second rsm no request", req_cnt, c0 + 2);
        chk("R7", "capture kept after exit", cap_addr, 32'h0008_1000);
        smi_high();
    endtask

    task automatic t_mem_rep();
        set_bus(1'b1, 1'b0, 1'b1, 3'd3, 32'h000A_0004, 32'h5555_AAAA, 32'h400, 32'h402);
        smi_low();
        chk("R5", "mem read addr", cap_addr, 32'h000A_0004);
        chk("R5", "mem read dvalid clear", {31'b0, cap_dvalid}, 32'd0);
        chk("R8", "rep string next ip", cap_ip_next, 32'h400);
        chk("R6", "size reserved code", {30'b0, cap_size}, 32'd3);
        do_rsm();
        smi_high();
    endtask

    task automatic t_cfg();
        logic [31:0] rd;
        cfg_write(1'b0, 1'b0, 32'h0004_0002);
        chk("R11", "gated base write ignored", hdr_eff_addr, 32'h0000_1000);
        cfg_read(1'b0, 1'b0, rd);
        chk("R11", "gated read zero", rd, 32'd0);
        cfg_read(1'b1, 1'b0, rd);
        chk("R11", "base unchanged after gated write", rd, 32'd0);
        cfg_write(1'b1, 1'b0, 32'h0004_0002);
        chk("R10", "recompute from base", hdr_eff_addr, 32'h0004_4000);
        cfg_read(1'b1, 1'b0, rd);
        chk("R11", "base readback", rd, 32'h0004_0002);
        cfg_write(1'b1, 1'b1, 32'h1234_5677);
        chk("R9", "header low bits ignored", hdr_eff_addr, 32'h1234_5674);
        cfg_read(1'b1, 1'b1, rd);
        chk("R9", "header readback aligned", rd, 32'h1234_5674);
        cfg_write(1'b0, 1'b1, 32'h0BAD_0000);
        chk("R11", "gated header write ignored", hdr_eff_addr, 32'h1234_5674);
        cfg_write(1'b1, 1'b0, 32'h0010_0000);
        chk("R10", "base write overwrites header", hdr_eff_addr, 32'h0010_1000);
    endtask

    initial begin
        t_reset();
        t_io_out();
        t_io_in_pending();
        t_mem_rep();
        t_cfg();
        chk("R1", "no back-to-back request", {31'b0, req_double}, 32'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule